// File: doc/BRIEF.md
# Linear Processing-Element Network with Responder Bypass

This block links a row of processing elements into a one-dimensional network for neighbour transfers. Each element holds one data register. Each element also has a data switch. The switch picks what the element drives outward: its own register, the broadcast word from the scalar unit, or the immediate word from the control unit. It also picks which incoming value reaches the element's execute stage: the value from the left, the value from the right, or its own driven value.

Every element has an activity bit, the top of its mask stack. An active element takes part in the network. An inactive element turns into a transparent pass-through, and its register is left alone. A shift therefore links each responder to the nearest responder on either side, however many inactive elements sit between them. The pass-through path is combinational, so every transfer completes in one clock edge. At the ends of the chain, the last active element receives a programmable fill word.

Top module: `pe_bypass_net`

## Requirements
- R1: After reset is asserted (rst_ni low), every element register reads 0 on pe_data_o. Element k occupies bits [k*DATA_W +: DATA_W].
- R2: With op_i = 3 (load) and src_i = 1 (broadcast), every active element stores bcast_i at the next rising edge.
- R3: With op_i = 3 and src_i = 2 or 3 (immediate), every active element stores imm_i at the next rising edge. With src_i = 0 (register), its value is unchanged.
- R4: With op_i = 1 (shift right, toward higher index), each active element stores the value driven by the nearest active element of lower index. The active element with the lowest index stores fill_i.
- R5: With op_i = 2 (shift left, toward lower index), each active element stores the value driven by the nearest active element of higher index. The active element with the highest index stores fill_i.
- R6: An element whose mask_i bit is 0 keeps its register unchanged during any operation. Inactive elements are skipped, so they never act as a source.
- R7: With op_i = 0 (idle), no register changes.
- R8: When mask_i is all zeros, no register changes for any op_i.
- R9: A shift completes in one edge whatever the number of inactive elements bypassed, including a hop across the whole array.
- R10: During a shift, an element drives the word chosen by src_i to its neighbours: its register (0), bcast_i (1) or imm_i (2, 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mask_i | input | N_PE | Activity bit per element (1 = in network) |
| op_i | input | 2 | 0 idle, 1 shift right, 2 shift left, 3 load |
| src_i | input | 2 | Driven word: 0 register, 1 broadcast, 2/3 immediate |
| bcast_i | input | DATA_W | Broadcast word from the scalar unit |
| imm_i | input | DATA_W | Immediate word from the control unit |
| fill_i | input | DATA_W | Word given to the end active element on a shift |
| pe_data_o | output | N_PE*DATA_W | Registers of all elements, element k at [k*DATA_W +: DATA_W] |

## Verification
Every operation takes effect at the first rising edge after its inputs are presented. pe_data_o is registered, so the result is due exactly one edge later. The bench applies the inputs on a falling edge and returns op_i to idle before the next falling edge. It then compares all elements against a reference computed from the requirements at that falling edge. So every check sees the effect of exactly one edge, and the far-hop case shows that no additional cycles are needed.

// File: rtl/pe_net_pkg.sv
package pe_net_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_SHR  = 2'd1,
    OP_SHL  = 2'd2,
    OP_LOAD = 2'd3
  } net_op_e;

  localparam logic [1:0] SRC_REG   = 2'd0;
  localparam logic [1:0] SRC_BCAST = 2'd1;
endpackage

// File: rtl/pe_net_switch.sv
module pe_net_switch
  import pe_net_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              active_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        src_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] bcast_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] from_left_i,
  input  logic [DATA_W-1:0] from_right_i,
  output logic [DATA_W-1:0] to_right_o,
  output logic [DATA_W-1:0] to_left_o,
  output logic [DATA_W-1:0] exec_o
);
  logic [DATA_W-1:0] drive;

  always_comb begin
    if (src_i[1])                drive = imm_i;
    else if (src_i == SRC_BCAST) drive = bcast_i;
    else                         drive = reg_i;
  end

  // inactive element is transparent in both directions
  assign to_right_o = active_i ? drive : from_left_i;
  assign to_left_o  = active_i ? drive : from_right_i;

  always_comb begin
    unique case (net_op_e'(op_i))
      OP_SHR:  exec_o = from_left_i;
      OP_SHL:  exec_o = from_right_i;
      OP_LOAD: exec_o = drive;
      default: exec_o = reg_i;
    endcase
  end
endmodule

// File: rtl/pe_net_cell.sv
module pe_net_cell
  import pe_net_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        src_i,
  input  logic [DATA_W-1:0] bcast_i,
  input  logic [DATA_W-1:0] exec_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    q_o <= '0;
    else if (active_i && (op_i != 2'(OP_IDLE)))     q_o <= exec_i;
  end

  // R6
  bypass_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(q_o));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'(OP_IDLE)) |=> $stable(q_o));
  // R2
  bcast_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && op_i == 2'(OP_LOAD) && src_i == SRC_BCAST) |=> (q_o == $past(bcast_i)));
endmodule

// File: rtl/pe_bypass_net.sv
module pe_bypass_net
  import pe_net_pkg::*;
#(
  parameter int N_PE   = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_PE-1:0]          mask_i,
  input  logic [1:0]               op_i,
  input  logic [1:0]               src_i,
  input  logic [DATA_W-1:0]        bcast_i,
  input  logic [DATA_W-1:0]        imm_i,
  input  logic [DATA_W-1:0]        fill_i,
  output logic [N_PE*DATA_W-1:0]   pe_data_o
);
  localparam int LAST = N_PE - 1;

  // rchain[k]: value arriving at element k from the left; lchain[k+1]: from the right
  logic [N_PE:0][DATA_W-1:0] rchain;
  logic [N_PE:0][DATA_W-1:0] lchain;

  assign rchain[0]    = fill_i;
  assign lchain[N_PE] = fill_i;

  for (genvar k = 0; k < N_PE; k++) begin : g_pe
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] exec;

    pe_net_switch #(.DATA_W(DATA_W)) u_sw (
      .active_i    (mask_i[k]),
      .op_i        (op_i),
      .src_i       (src_i),
      .reg_i       (q),
      .bcast_i     (bcast_i),
      .imm_i       (imm_i),
      .from_left_i (rchain[k]),
      .from_right_i(lchain[k+1]),
      .to_right_o  (rchain[k+1]),
      .to_left_o   (lchain[k]),
      .exec_o      (exec)
    );

    pe_net_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .active_i(mask_i[k]),
      .op_i    (op_i),
      .src_i   (src_i),
      .bcast_i (bcast_i),
      .exec_i  (exec),
      .q_o     (q)
    );

    assign pe_data_o[k*DATA_W +: DATA_W] = q;
  end

  // R8
  no_active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> $stable(pe_data_o));
  // R4
  shr_head_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i[0] && op_i == 2'(OP_SHR)) |=> (pe_data_o[DATA_W-1:0] == $past(fill_i)));
  // R5
  shl_tail_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i[LAST] && op_i == 2'(OP_SHL)) |=> (pe_data_o[LAST*DATA_W +: DATA_W] == $past(fill_i)));
endmodule

// File: tb/pe_bypass_net_tb_top.sv
module pe_bypass_net_tb_top;
  localparam int N  = 8;
  localparam int W  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   mask = '0;
  logic [1:0]     op = 2'd0;
  logic [1:0]     src = 2'd0;
  logic [W-1:0]   bcast = '0, imm = '0, fill = '0;
  logic [N*W-1:0] data;

  logic [W-1:0] exp_q [N];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pe_bypass_net #(.N_PE(N), .DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mask_i(mask), .op_i(op), .src_i(src),
    .bcast_i(bcast), .imm_i(imm), .fill_i(fill), .pe_data_o(data)
  );

  function automatic logic [W-1:0] drv(int k, logic [1:0] s, logic [W-1:0] b, logic [W-1:0] im);
    if (s[1])      return im;
    else if (s[0]) return b;
    else           return exp_q[k];
  endfunction

  task automatic model(logic [N-1:0] m, logic [1:0] o, logic [1:0] s,
                       logic [W-1:0] b, logic [W-1:0] im, logic [W-1:0] f);
    logic [W-1:0] nxt [N];
    for (int k = 0; k < N; k++) begin
      nxt[k] = exp_q[k];
      if (m[k]) begin
        case (o)
          2'd1: begin
            nxt[k] = f;
            for (int j = 0; j < k; j++) if (m[j]) nxt[k] = drv(j, s, b, im);
          end
          2'd2: begin
            nxt[k] = f;
            for (int j = N-1; j > k; j--) if (m[j]) nxt[k] = drv(j, s, b, im);
          end
          2'd3: nxt[k] = drv(k, s, b, im);
          default: ;
        endcase
      end
    end
    for (int k = 0; k < N; k++) exp_q[k] = nxt[k];
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < N; k++) begin
      checks++;
      if (data[k*W +: W] !== exp_q[k]) begin
        errors++;
        $display("FAIL %s pe%0d actual=%h expected=%h", req, k, data[k*W +: W], exp_q[k]);
      end
    end
  endtask

  // apply at falling edge, one rising edge, sample at following falling edge
  task automatic do_op(logic [N-1:0] m, logic [1:0] o, logic [1:0] s,
                       logic [W-1:0] b, logic [W-1:0] im, logic [W-1:0] f, string req);
    @(negedge clk);
    mask = m; op = o; src = s; bcast = b; imm = im; fill = f;
    model(m, o, s, b, im, f);
    @(negedge clk);
    op = 2'd0; mask = '0;
    check_all(req);
  endtask

  task automatic t_reset;
    for (int k = 0; k < N; k++) exp_q[k] = '0;
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
  endtask

  task automatic t_seed;
    for (int k = 0; k < N; k++)
      do_op(N'(1) << k, 2'd3, 2'd2, 16'hDEAD, 16'h0A00 + 16'(k), 16'h0, "R3");
    do_op(8'hFF, 2'd3, 2'd0, 16'h1111, 16'h2222, 16'h0, "R3");
  endtask

  task automatic t_bcast;
    do_op(8'b1010_0101, 2'd3, 2'd1, 16'hB0B0, 16'h2222, 16'h0, "R2");
    do_op(8'b0101_1010, 2'd3, 2'd3, 16'h0, 16'hC0C0, 16'h0, "R3");
    for (int k = 0; k < N; k++)
      do_op(N'(1) << k, 2'd3, 2'd2, 16'h0, 16'h0100 + 16'(k), 16'h0, "R3");
  endtask

  task automatic t_shr;
    do_op(8'b1001_0010, 2'd1, 2'd0, 16'h0, 16'h0, 16'hF00D, "R4");
    do_op(8'b0110_1101, 2'd1, 2'd0, 16'h0, 16'h0, 16'hF11D, "R6");
  endtask

  task automatic t_shl;
    do_op(8'b0110_0001, 2'd2, 2'd0, 16'h0, 16'h0, 16'hE00E, "R5");
    do_op(8'b1011_0110, 2'd2, 2'd0, 16'h0, 16'h0, 16'hE11E, "R5");
  endtask

  task automatic t_far;
    do_op(8'b0000_0001, 2'd3, 2'd2, 16'h0, 16'h5A5A, 16'h0, "R9");
    do_op(8'b1000_0001, 2'd1, 2'd0, 16'h0, 16'h0, 16'h7777, "R9");
    do_op(8'b1000_0001, 2'd2, 2'd0, 16'h0, 16'h0, 16'h3333, "R9");
  endtask

  task automatic t_src_shift;
    do_op(8'b1100_1010, 2'd1, 2'd1, 16'hBEEF, 16'h0, 16'h4444, "R10");
    do_op(8'b0011_0101, 2'd2, 2'd2, 16'h0, 16'hCAFE, 16'h5555, "R10");
  endtask

  task automatic t_idle;
    do_op(8'hFF, 2'd0, 2'd1, 16'h9999, 16'h8888, 16'h7777, "R7");
    do_op(8'h00, 2'd1, 2'd0, 16'h0, 16'h0, 16'h6666, "R8");
    do_op(8'h00, 2'd3, 2'd1, 16'h1234, 16'h0, 16'h0, "R8");
  endtask

  initial begin
    t_reset();
    t_seed();
    t_bcast();
    t_shr();
    t_shl();
    t_far();
    t_src_shift();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule